// File: doc/BRIEF.md
# 16-bit Multicycle Processor Core

This block is a small sequential processor for a 16-bit load/store instruction set. It has eight general registers, a program counter and a one-hot set of three condition flags (negative, zero, positive). Instructions run one at a time through a short state machine: fetch, capture, execute, and up to two extra memory states for loads, indirect accesses and trap vectors. All traffic goes over one word-addressed memory port. A read returns its data in the cycle after the request.

The instruction set covers register and immediate arithmetic and logic, three load/store addressing forms, conditional branches, jumps, subroutine calls and system calls through a vector table in low memory. A system call to a parameterised halt vector stops the core. Opcode 1101 stops it with an exception output. A debug port reads any register combinationally and shows the live flags.

Top module: `mc16_core`

## Requirements
- R1: While reset is held and after it is released, the core fetches first from RESET_PC (default 16'h3000). All eight registers read zero and the flags `cc_flags` (bit 2 = N, bit 1 = Z, bit 0 = P) are 3'b010.
- R2: ADD (opcode 0001) and AND (opcode 0101) take their second operand from the register in bits 2:0 when bit 5 is 0. When bit 5 is 1 they take the 5-bit immediate in bits 4:0, sign-extended. The destination is bits 11:9 and the first source is bits 8:6.
- R3: NOT (opcode 1001) writes the complement of the register in bits 8:6. ADD, AND, NOT, LD, LDI, LDR and LEA set exactly one flag, according to the sign and zero state of the value they write.
- R4: Stores, branches, jumps, calls and traps leave the flags unchanged.
- R5: A branch (opcode 0000) is taken when any of its enable bits 11 (N), 10 (Z), 9 (P) matches a set flag. The target is PC+1 plus the sign-extended bits 8:0. With mask 000 the branch is never taken.
- R6: LD (0010), ST (0011) and LEA (1110) use PC+1 plus the sign-extended bits 8:0. LDR (0110) and STR (0111) use the register in bits 8:6 plus the sign-extended bits 5:0. The register in bits 11:9 is the one loaded or stored.
- R7: LDI (1010) and STI (1011) first read the PC-relative location. The word read there is the address of the final load or store.
- R8: JSR (0100) with bit 11 = 1 jumps to PC+1 plus the sign-extended bits 10:0. With bit 11 = 0 it jumps to the register in bits 8:6, read before R7 is written. In both forms R7 receives PC+1.
- R9: JMP (1100) loads the PC from the register in bits 8:6. With that field set to 7 it acts as a return.
- R10: TRAP (1111) writes PC+1 to R7 and loads the PC from memory at the zero-extended bits 7:0. When bits 7:0 equal HALT_VEC (default 8'h25), `halted` instead rises and stays high, and no further memory requests are made.
- R11: Opcode 1101 raises `illegal_op`, which stays high with no further memory requests until reset. Opcode 1000 is executed as a no-op.
- R12: Read data is taken from `mem_rdata` one cycle after the request. `mem_we` is only ever high together with `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| dbg_sel | input | 3 | Register selected for the debug port |
| dbg_reg | output | 16 | Contents of the selected register |
| cc_flags | output | 3 | Condition flags N, Z, P |
| halted | output | 1 | Halt trap executed |
| illegal_op | output | 1 | Unused opcode encountered |

## Verification
Four programs exercise the instruction stream. The first is a straight arithmetic run that mixes register and immediate operands with negative immediates, which shows whether the bit-5 operand select and sign extension are right. The second runs every load and store addressing form against a memory image with known words. It predicts each write address and value, which separates PC-relative, base-offset and indirect address paths, and it checks that stores leave the flags from the last load untouched. The third is a control-flow program that covers taken, not-taken and never-taken branches, a backward loop, both call forms including a call through R7, and a vectored trap; its final register values only come out right if every target was computed correctly. The fourth places a no-op opcode and then the unused opcode, and checks that execution stops exactly there.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

   localparam int unsigned WORD_W = 16;
   localparam int unsigned NREGS  = 8;

   typedef enum logic [3:0] {
      OP_BR   = 4'b0000,
      OP_ADD  = 4'b0001,
      OP_LD   = 4'b0010,
      OP_ST   = 4'b0011,
      OP_JSR  = 4'b0100,
      OP_AND  = 4'b0101,
      OP_LDR  = 4'b0110,
      OP_STR  = 4'b0111,
      OP_NOP8 = 4'b1000,
      OP_NOT  = 4'b1001,
      OP_LDI  = 4'b1010,
      OP_STI  = 4'b1011,
      OP_JMP  = 4'b1100,
      OP_BAD  = 4'b1101,
      OP_LEA  = 4'b1110,
      OP_TRAP = 4'b1111
   } opc_e;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_LATCH,
      ST_EXEC,
      ST_RDWAIT,
      ST_INDWAIT,
      ST_VECWAIT,
      ST_STOP,
      ST_FAULT
   } state_e;

   typedef enum logic [1:0] {
      ALU_ADD,
      ALU_AND,
      ALU_NOT,
      ALU_PASS
   } alu_op_e;

   function automatic logic [2:0] flags_of(input logic [WORD_W-1:0] v);
      logic zero;
      zero = (v == '0);
      return {v[WORD_W-1], zero, ~v[WORD_W-1] & ~zero};
   endfunction

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
   parameter int unsigned W  = 16,
   parameter int unsigned N  = 8,
   localparam int unsigned AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_data,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);

   if (N != (1 << AW)) begin : g_chk_pow2
      $error("mc16_regfile: register count must be a power of two");
   end
   if (W < 2) begin : g_chk_width
      $error("mc16_regfile: word width too small");
   end

   logic [W-1:0] regs [N];

   for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
         end else if (we && (waddr == AW'(i))) begin
            regs[i] <= wdata;
         end
      end
   end

   assign ra_data = regs[ra_addr];
   assign rb_data = regs[rb_addr];
   assign rd_data = regs[rd_addr];

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
   import mc16_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_AND: y = a & b;
         ALU_NOT: y = ~a;
         default: y = b;
      endcase
   end

endmodule

// File: rtl/mc16_agen.sv
module mc16_agen #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] pc_inc,
   input  logic [10:0]  ofs,
   input  logic [W-1:0] base,
   output logic [W-1:0] tgt9,
   output logic [W-1:0] tgt11,
   output logic [W-1:0] base6
);

   if (W < 12) begin : g_chk_width
      $error("mc16_agen: word width must hold an 11-bit offset");
   end

   logic [W-1:0] sx9, sx11, sx6;

   assign sx9   = {{(W-9){ofs[8]}}, ofs[8:0]};
   assign sx11  = {{(W-11){ofs[10]}}, ofs[10:0]};
   assign sx6   = {{(W-6){ofs[5]}}, ofs[5:0]};

   assign tgt9  = pc_inc + sx9;
   assign tgt11 = pc_inc + sx11;
   assign base6 = base + sx6;

endmodule

// File: rtl/mc16_core.sv
module mc16_core
   import mc16_pkg::*;
#(
   parameter logic [15:0] RESET_PC = 16'h3000,
   parameter logic [7:0]  HALT_VEC = 8'h25
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        mem_req,
   output logic        mem_we,
   output logic [15:0] mem_addr,
   output logic [15:0] mem_wdata,
   input  logic [15:0] mem_rdata,
   input  logic [2:0]  dbg_sel,
   output logic [15:0] dbg_reg,
   output logic [2:0]  cc_flags,
   output logic        halted,
   output logic        illegal_op
);

   localparam int unsigned W   = WORD_W;
   localparam int unsigned RAW = $clog2(NREGS);
   localparam logic [RAW-1:0] LINK_REG = RAW'(NREGS - 1);

   if (W != 16) begin : g_chk_word
      $error("mc16_core: instruction encoding assumes 16-bit words");
   end

   state_e         state_q, state_d;
   logic [W-1:0]   pc_q, pc_d;
   logic [W-1:0]   ir_q;
   logic           ir_we;
   logic [2:0]     cc_q;
   logic           cc_we;

   opc_e           opc;
   logic [RAW-1:0] f_dr, f_sr1, f_sr2;
   logic           imm_mode;
   logic [W-1:0]   imm5_sx;

   logic           rf_we;
   logic [RAW-1:0] rf_waddr;
   logic [W-1:0]   rf_wdata;
   logic [RAW-1:0] rb_addr;
   logic [W-1:0]   ra_data, rb_data;

   alu_op_e        alu_op;
   logic [W-1:0]   alu_b, alu_y;
   logic [W-1:0]   tgt9, tgt11, base6;
   logic           br_take;
   logic           is_store;

   // field decode
   assign opc      = opc_e'(ir_q[15:12]);
   assign f_dr     = ir_q[11:9];
   assign f_sr1    = ir_q[8:6];
   assign f_sr2    = ir_q[2:0];
   assign imm_mode = ir_q[5];
   assign imm5_sx  = {{(W-5){ir_q[4]}}, ir_q[4:0]};
   assign is_store = (opc == OP_ST) || (opc == OP_STR) || (opc == OP_STI);
   assign rb_addr  = is_store ? f_dr : f_sr2;
   assign alu_b    = imm_mode ? imm5_sx : rb_data;
   assign br_take  = |(ir_q[11:9] & cc_q);

   always_comb begin
      case (opc)
         OP_ADD:  alu_op = ALU_ADD;
         OP_AND:  alu_op = ALU_AND;
         OP_NOT:  alu_op = ALU_NOT;
         default: alu_op = ALU_PASS;
      endcase
   end

   mc16_regfile #(.W(W), .N(NREGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .ra_addr (f_sr1),
      .ra_data (ra_data),
      .rb_addr (rb_addr),
      .rb_data (rb_data),
      .rd_addr (dbg_sel),
      .rd_data (dbg_reg)
   );

   mc16_alu #(.W(W)) u_alu (
      .op (alu_op),
      .a  (ra_data),
      .b  (alu_b),
      .y  (alu_y)
   );

   mc16_agen #(.W(W)) u_agen (
      .pc_inc (pc_q),
      .ofs    (ir_q[10:0]),
      .base   (ra_data),
      .tgt9   (tgt9),
      .tgt11  (tgt11),
      .base6  (base6)
   );

   // sequencing
   always_comb begin
      state_d   = state_q;
      pc_d      = pc_q;
      ir_we     = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = pc_q;
      mem_wdata = rb_data;
      rf_we     = 1'b0;
      rf_waddr  = f_dr;
      rf_wdata  = alu_y;
      cc_we     = 1'b0;

      case (state_q)
         ST_FETCH: begin
            mem_req = 1'b1;
            state_d = ST_LATCH;
         end
         ST_LATCH: begin
            ir_we   = 1'b1;
            pc_d    = pc_q + 1'b1;
            state_d = ST_EXEC;
         end
         ST_EXEC: begin
            state_d = ST_FETCH;
            case (opc)
               OP_ADD, OP_AND, OP_NOT: begin
                  rf_we = 1'b1;
                  cc_we = 1'b1;
               end
               OP_LEA: begin
                  rf_we    = 1'b1;
                  rf_wdata = tgt9;
                  cc_we    = 1'b1;
               end
               OP_BR: begin
                  if (br_take) pc_d = tgt9;
               end
               OP_JMP: begin
                  pc_d = ra_data;
               end
               OP_JSR: begin
                  rf_we    = 1'b1;
                  rf_waddr = LINK_REG;
                  rf_wdata = pc_q;
                  pc_d     = ir_q[11] ? tgt11 : ra_data;
               end
               OP_LD: begin
                  mem_req  = 1'b1;
                  mem_addr = tgt9;
                  state_d  = ST_RDWAIT;
               end
               OP_LDR: begin
                  mem_req  = 1'b1;
                  mem_addr = base6;
                  state_d  = ST_RDWAIT;
               end
               OP_LDI, OP_STI: begin
                  mem_req  = 1'b1;
                  mem_addr = tgt9;
                  state_d  = ST_INDWAIT;
               end
               OP_ST: begin
                  mem_req  = 1'b1;
                  mem_we   = 1'b1;
                  mem_addr = tgt9;
               end
               OP_STR: begin
                  mem_req  = 1'b1;
                  mem_we   = 1'b1;
                  mem_addr = base6;
               end
               OP_TRAP: begin
                  rf_we    = 1'b1;
                  rf_waddr = LINK_REG;
                  rf_wdata = pc_q;
                  if (ir_q[7:0] == HALT_VEC) begin
                     state_d = ST_STOP;
                  end else begin
                     mem_req  = 1'b1;
                     mem_addr = {{(W-8){1'b0}}, ir_q[7:0]};
                     state_d  = ST_VECWAIT;
                  end
               end
               OP_BAD: begin
                  state_d = ST_FAULT;
               end
               default: begin
                  state_d = ST_FETCH;
               end
            endcase
         end
         ST_RDWAIT: begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
            cc_we    = 1'b1;
            state_d  = ST_FETCH;
         end
         ST_INDWAIT: begin
            mem_req  = 1'b1;
            mem_addr = mem_rdata;
            if (opc == OP_LDI) begin
               state_d = ST_RDWAIT;
            end else begin
               mem_we  = 1'b1;
               state_d = ST_FETCH;
            end
         end
         ST_VECWAIT: begin
            pc_d    = mem_rdata;
            state_d = ST_FETCH;
         end
         default: begin
            state_d = state_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= RESET_PC;
         ir_q    <= '0;
         cc_q    <= 3'b010;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         if (ir_we) ir_q <= mem_rdata;
         if (cc_we) cc_q <= flags_of(rf_wdata);
      end
   end

   assign cc_flags   = cc_q;
   assign halted     = (state_q == ST_STOP);
   assign illegal_op = (state_q == ST_FAULT);

endmodule

// File: rtl/mc16_core_checker.sv
module mc16_core_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       mem_req,
   input logic       mem_we,
   input logic [2:0] cc_flags,
   input logic       halted,
   input logic       illegal_op
);

   assert_we_with_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cc_flags) == 1);

   assert_store_keeps_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> $stable(cc_flags));

   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_req));

   assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |=> (illegal_op && !mem_req));

   assert_stop_states_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted && illegal_op));

endmodule

bind mc16_core mc16_core_checker u_mc16_core_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .cc_flags   (cc_flags),
   .halted     (halted),
   .illegal_op (illegal_op)
);

// File: tb/mc16_core_bench.sv
`timescale 1ns/1ps
module mc16_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic [2:0]  dbg_sel = '0;
   logic [15:0] dbg_reg;
   logic [2:0]  cc_flags;
   logic        halted, illegal_op;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [15:0] a;
      logic [15:0] d;
      string       tag;
   } wr_t;
   wr_t exp_q[$];

   logic [15:0] mem [logic [15:0]];

   always #2 clk = ~clk;

   mc16_core u_mc16_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .dbg_sel    (dbg_sel),
      .dbg_reg    (dbg_reg),
      .cc_flags   (cc_flags),
      .halted     (halted),
      .illegal_op (illegal_op)
   );

   function automatic logic [15:0] mem_rd(input logic [15:0] a);
      if (mem.exists(a)) return mem[a];
      return 16'h0000;
   endfunction

   // memory model: read data valid the cycle after the request
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] = mem_wdata;
         else        mem_rdata <= mem_rd(mem_addr);
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_write(input logic [15:0] a, input logic [15:0] d, input string tag);
      wr_t it;
      it.a = a; it.d = d; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_we) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 unexpected write actual=%h expected=none", mem_addr);
         end else begin
            wr_t it;
            it = exp_q.pop_front();
            chk({it.tag, " write address"}, mem_addr, it.a);
            chk({it.tag, " write data"}, mem_wdata, it.d);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // instruction encoders
   function automatic logic [15:0] e_addr(input logic [2:0] d, s1, s2);
      return {4'b0001, d, s1, 3'b000, s2};
   endfunction
   function automatic logic [15:0] e_addi(input logic [2:0] d, s1, input logic [4:0] im);
      return {4'b0001, d, s1, 1'b1, im};
   endfunction
   function automatic logic [15:0] e_andr(input logic [2:0] d, s1, s2);
      return {4'b0101, d, s1, 3'b000, s2};
   endfunction
   function automatic logic [15:0] e_andi(input logic [2:0] d, s1, input logic [4:0] im);
      return {4'b0101, d, s1, 1'b1, im};
   endfunction
   function automatic logic [15:0] e_not(input logic [2:0] d, s);
      return {4'b1001, d, s, 6'h3F};
   endfunction
   function automatic logic [15:0] e_br(input logic [2:0] m, input logic [8:0] o);
      return {4'b0000, m, o};
   endfunction
   function automatic logic [15:0] e_pc(input logic [3:0] op, input logic [2:0] r, input logic [8:0] o);
      return {op, r, o};
   endfunction
   function automatic logic [15:0] e_bo(input logic [3:0] op, input logic [2:0] r, b, input logic [5:0] o);
      return {op, r, b, o};
   endfunction
   function automatic logic [15:0] e_jsr(input logic [10:0] o);
      return {5'b01001, o};
   endfunction
   function automatic logic [15:0] e_jsrr(input logic [2:0] b);
      return {4'b0100, 3'b000, b, 6'b0};
   endfunction
   function automatic logic [15:0] e_jmp(input logic [2:0] b);
      return {4'b1100, 3'b000, b, 6'b0};
   endfunction
   function automatic logic [15:0] e_trap(input logic [7:0] v);
      return {8'hF0, v};
   endfunction

   task automatic peek(input logic [2:0] r, output logic [15:0] v);
      dbg_sel = r;
      #0.5;
      v = dbg_reg;
   endtask

   task automatic chk_reg(input string tag, input logic [2:0] r, input logic [15:0] exp);
      logic [15:0] v;
      peek(r, v);
      chk(tag, v, exp);
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      mem.delete();
      exp_q.delete();
   endtask

   task automatic run_to_stop(input string tag);
      int cyc = 0;
      @(negedge clk);
      rst_n = 1'b1;
      while (!halted && !illegal_op && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      chk({tag, " program stopped"}, 16'(cyc < 3000), 16'h1);
   endtask

   initial begin
      logic [15:0] v;

      // program 1: arithmetic and logic
      enter_reset();
      mem[16'h3000] = e_andi(0, 0, 5'h00);
      mem[16'h3001] = e_addi(1, 0, 5'h10);
      mem[16'h3002] = e_addi(2, 0, 5'h0F);
      mem[16'h3003] = e_addr(3, 1, 2);
      mem[16'h3004] = e_andr(4, 3, 2);
      mem[16'h3005] = e_not(5, 2);
      mem[16'h3006] = e_andi(6, 3, 5'h1E);
      mem[16'h3007] = e_trap(8'h25);
      repeat (2) @(negedge clk);
      chk("R1 reset fetch request", 16'(mem_req), 16'h1);
      chk("R1 reset fetch address", mem_addr, 16'h3000);
      chk("R1 reset flags", 16'(cc_flags), 16'h0002);
      for (int i = 0; i < 8; i++) begin
         peek(3'(i), v);
         chk("R1 reset register", v, 16'h0000);
      end
      run_to_stop("R10 prog1");
      chk_reg("R2 AND immediate zero", 0, 16'h0000);
      chk_reg("R2 ADD negative immediate", 1, 16'hFFF0);
      chk_reg("R2 ADD positive immediate", 2, 16'h000F);
      chk_reg("R2 ADD register mode", 3, 16'hFFFF);
      chk_reg("R2 AND register mode", 4, 16'h000F);
      chk_reg("R3 NOT complement", 5, 16'hFFF0);
      chk_reg("R2 AND negative immediate", 6, 16'hFFFE);
      chk_reg("R10 halt trap links R7", 7, 16'h3008);
      chk("R3 flags negative", 16'(cc_flags), 16'h0004);
      chk("R10 halted high", 16'(halted), 16'h1);
      repeat (3) @(negedge clk);
      chk("R10 no request after halt", 16'(mem_req), 16'h0);

      // program 2: loads and stores
      enter_reset();
      mem[16'h3000] = e_pc(4'b0010, 1, 9'h00F);
      mem[16'h3001] = e_pc(4'b1110, 2, 9'h00E);
      mem[16'h3002] = e_pc(4'b1010, 4, 9'h010);
      mem[16'h3003] = e_bo(4'b0110, 3, 2, 6'h01);
      mem[16'h3004] = e_pc(4'b0011, 1, 9'h00D);
      mem[16'h3005] = e_bo(4'b0111, 1, 2, 6'h3E);
      mem[16'h3006] = e_pc(4'b1011, 4, 9'h00E);
      mem[16'h3007] = e_trap(8'h25);
      mem[16'h3010] = 16'h8001;
      mem[16'h3011] = 16'h0000;
      mem[16'h3012] = 16'h0000;
      mem[16'h3013] = 16'h3014;
      mem[16'h3014] = 16'h1234;
      mem[16'h3015] = 16'h4000;
      expect_write(16'h3012, 16'h8001, "R6 ST");
      expect_write(16'h300E, 16'h8001, "R6 STR");
      expect_write(16'h4000, 16'h1234, "R7 STI");
      run_to_stop("R10 prog2");
      chk_reg("R6 LD pc-relative", 1, 16'h8001);
      chk_reg("R6 LEA address", 2, 16'h3010);
      chk_reg("R6 LDR base offset", 3, 16'h0000);
      chk_reg("R7 LDI indirect", 4, 16'h1234);
      chk("R4 flags kept through stores", 16'(cc_flags), 16'h0002);
      chk("R12 all writes seen", 16'(exp_q.size()), 16'h0000);

      // program 3: control flow
      enter_reset();
      mem[16'h0030] = 16'h3100;
      mem[16'h3000] = e_andi(0, 0, 5'h00);
      mem[16'h3001] = e_br(3'b100, 9'h001);
      mem[16'h3002] = e_addi(1, 0, 5'h05);
      mem[16'h3003] = e_br(3'b010, 9'h001);
      mem[16'h3004] = e_addi(2, 0, 5'h07);
      mem[16'h3005] = e_br(3'b001, 9'h001);
      mem[16'h3006] = e_addi(2, 0, 5'h1F);
      mem[16'h3007] = e_br(3'b000, 9'h001);
      mem[16'h3008] = e_addi(3, 0, 5'h03);
      mem[16'h3009] = e_jsr(11'h010);
      mem[16'h300A] = e_trap(8'h30);
      mem[16'h300B] = e_pc(4'b1110, 7, 9'h024);
      mem[16'h300C] = e_jsrr(7);
      mem[16'h300D] = e_addi(2, 2, 5'h01);
      mem[16'h300E] = e_addi(1, 1, 5'h1F);
      mem[16'h300F] = e_br(3'b001, 9'h1FD);
      mem[16'h3010] = e_trap(8'h25);
      mem[16'h301A] = e_addi(4, 0, 5'h09);
      mem[16'h301B] = e_jmp(7);
      mem[16'h3030] = e_addi(5, 7, 5'h00);
      mem[16'h3031] = e_jmp(7);
      mem[16'h3100] = e_addi(6, 6, 5'h01);
      mem[16'h3101] = e_jmp(7);
      run_to_stop("R10 prog3");
      chk_reg("R5 not-taken branch executed fall-through", 1, 16'h0000);
      chk_reg("R5 taken, mask-000 and backward branches", 2, 16'h000C);
      chk_reg("R5 mask 000 never taken", 3, 16'h0003);
      chk_reg("R8 JSR offset form and R9 return", 4, 16'h0009);
      chk_reg("R8 JSRR through R7 reads base first", 5, 16'h300D);
      chk_reg("R10 vectored trap ran service", 6, 16'h0001);
      chk_reg("R10 halt trap link", 7, 16'h3011);
      chk("R4 flags after jumps and traps", 16'(cc_flags), 16'h0002);

      // program 4: no-op opcode and unused opcode
      enter_reset();
      mem[16'h3000] = e_addi(1, 0, 5'h01);
      mem[16'h3001] = 16'h8000;
      mem[16'h3002] = e_addi(2, 0, 5'h02);
      mem[16'h3003] = 16'hD000;
      mem[16'h3004] = e_addi(3, 0, 5'h03);
      run_to_stop("R11 prog4");
      repeat (5) @(negedge clk);
      chk("R11 exception raised", 16'(illegal_op), 16'h1);
      chk("R11 not halted", 16'(halted), 16'h0);
      chk("R11 no request after fault", 16'(mem_req), 16'h0);
      chk_reg("R11 before fault", 1, 16'h0001);
      chk_reg("R11 opcode 1000 is a no-op", 2, 16'h0002);
      chk_reg("R11 nothing after fault", 3, 16'h0000);
      chk("R11 flags from last write", 16'(cc_flags), 16'h0001);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule